// File: doc/BRIEF.md
# DDR2 Read Latency Scheduler

This block sits on the controller side of a DDR2-style memory interface. It keeps its own copy of three programmed settings: the CAS latency, the posted additive latency and the choice of exit type for active power-down. The command path gives it a strobe for every READ it wants to issue. For each READ the block accepts, it raises a data-valid window exactly on the clock where the first read data is due. The window lasts for as many clocks as the burst occupies. Several READs may be in flight at once, and their windows are ORed together.

The block also guards READ issue around power-down. When power-down is entered, the read-allowed output drops. After exit, it stays low for a programmable number of clocks. For active power-down, that count comes from the fast-exit or slow-exit setting, selected by a mode bit. For precharge power-down, the fast count is always used. A READ strobe that arrives while read-allowed is low is dropped. Any configuration write with an illegal value is rejected as a whole, and an error flag is raised.

Top module: `ddr2_rd_lat_sched`

## Requirements
- R1: After reset the block behaves as follows: data_valid is low, rd_allowed is high and cfg_error is low. The CAS latency is 3, the additive latency is 0 and fast exit is selected.
- R2: A write with cfg_sel=0 holds the CAS latency in cfg_wdata[6:4]. The field value is the latency in clocks. The values 3, 4 and 5 are legal. The value 6 is legal only when ENABLE_CL6 is set, and by default it is not.
- R3: A cfg_sel=0 write with a reserved CAS field (0, 1, 2, 7, or 6 when ENABLE_CL6 is not set) is discarded as a whole. The CAS latency and the exit-mode bit keep their old values, and cfg_error is high from the next clock. Any accepted write clears cfg_error on the next clock.
- R4: A write with cfg_sel=1 holds the additive latency in cfg_wdata[2:0]. Values 0 to 4 are accepted. Values 5 to 7 are rejected: the additive latency is kept and cfg_error is set.
- R5: A READ accepted at clock edge n raises data_valid as a result of edge n+AL+CL. AL and CL are the settings in force at edge n.
- R6: Each accepted READ holds data_valid high for BURST_LEN/2 clocks. With the default 4-beat burst, this is 2 clocks.
- R7: Any number of READs may be outstanding, including a READ on every clock and READs issued under different latencies. data_valid is the OR of all their windows.
- R8: A READ strobe sampled while rd_allowed is low is dropped. It never produces a data-valid window.
- R9: pd_enter, sampled while running, starts power-down and drops rd_allowed from the next clock. pd_enter_active=1 at that edge marks it as active power-down, and 0 marks it as precharge power-down.
- R10: A pd_exit sampled at edge e, leaving active power-down, raises rd_allowed as a result of edge e+T. T is T_FAST (default 2) when mode bit cfg_wdata[12] was written as 0, and T_SLOW (default 6) when it was written as 1.
- R11: Leaving precharge power-down always uses T_FAST, whatever the value of the exit-mode bit.
- R12: pd_exit has no effect unless the block is in power-down. pd_enter has no effect while in power-down or while waiting after an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronized internally. |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: mode word (CAS latency, exit mode), 1: additive latency |
| cfg_wdata | input | 16 | Configuration write data |
| rd_cmd | input | 1 | READ command strobe |
| pd_enter | input | 1 | Power-down entry strobe |
| pd_enter_active | input | 1 | Kind of power-down being entered: 1 active, 0 precharge |
| pd_exit | input | 1 | Power-down exit strobe |
| data_valid | output | 1 | High on the clocks where read data is due |
| rd_allowed | output | 1 | High when a READ may be issued |
| cfg_error | output | 1 | The last configuration write was rejected |

## Verification
The assertions assume the following about the inputs. No configuration write arrives during the two clocks in which the internal reset is still being released. The strobes are single-clock pulses, synchronous to clk. The reject properties also rely on the reset values being legal, so the held value is always one of the legal latencies. The stimulus waits several idle clocks after reset release before it drives any strobe. It issues each strobe for one clock from the falling edge. It aims pd_enter and pd_exit at every state of the power-down sequence, so that the ignored cases are reached on purpose.

// File: rtl/ddr2_rdlat_pkg.sv
`timescale 1ns/1ps
package ddr2_rdlat_pkg;

  localparam int CFG_DW  = 16;
  localparam int CL_LSB  = 4;
  localparam int CL_W    = 3;
  localparam int PDX_BIT = 12;
  localparam int AL_W    = 3;

  typedef enum logic [1:0] {
    PD_RUN  = 2'd0,
    PD_DOWN = 2'd1,
    PD_WAIT = 2'd2
  } pd_state_e;

  function automatic logic cl_code_ok(input logic [CL_W-1:0] code, input logic allow6);
    case (code)
      3'd3, 3'd4, 3'd5: return 1'b1;
      3'd6:             return allow6;
      default:          return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rdlat_rst_sync.sv
`timescale 1ns/1ps
module rdlat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/rdlat_cfg.sv
`timescale 1ns/1ps
module rdlat_cfg
  import ddr2_rdlat_pkg::*;
#(
  parameter bit ENABLE_CL6 = 1'b0,
  parameter int AL_MAX     = 4,
  parameter int RESET_CL   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CL_W-1:0]   cl_q,
  output logic [AL_W-1:0]   al_q,
  output logic              slow_exit_q,
  output logic              cfg_error_q
);

  logic [CL_W-1:0] cl_field, cl_d;
  logic [AL_W-1:0] al_field, al_d;
  logic            slow_d, err_d;
  logic            mode_ok, al_ok, upd_en;
  logic            unused_cfg_bits;

  assign cl_field = cfg_wdata[CL_LSB +: CL_W];
  assign al_field = cfg_wdata[AL_W-1:0];
  assign mode_ok  = cl_code_ok(cl_field, ENABLE_CL6);
  assign al_ok    = (int'(al_field) <= AL_MAX);
  assign upd_en   = cfg_we;

  assign unused_cfg_bits = ^{cfg_wdata[CFG_DW-1:PDX_BIT+1],
                             cfg_wdata[PDX_BIT-1:CL_LSB+CL_W],
                             cfg_wdata[CL_LSB-1:AL_W]};

  always_comb begin
    cl_d   = cl_q;
    al_d   = al_q;
    slow_d = slow_exit_q;
    err_d  = cfg_error_q;
    if (cfg_we) begin
      if (!cfg_sel) begin
        if (mode_ok) begin
          cl_d   = cl_field;
          slow_d = cfg_wdata[PDX_BIT];
          err_d  = 1'b0;
        end else begin
          err_d  = 1'b1;
        end
      end else begin
        if (al_ok) begin
          al_d  = al_field;
          err_d = 1'b0;
        end else begin
          err_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q        <= CL_W'(RESET_CL);
      al_q        <= '0;
      slow_exit_q <= 1'b0;
      cfg_error_q <= 1'b0;
    end else if (upd_en) begin
      cl_q        <= cl_d;
      al_q        <= al_d;
      slow_exit_q <= slow_d;
      cfg_error_q <= err_d;
    end
  end

endmodule

// File: rtl/rdlat_pd_gate.sv
`timescale 1ns/1ps
module rdlat_pd_gate
  import ddr2_rdlat_pkg::*;
#(
  parameter int T_FAST = 2,
  parameter int T_SLOW = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_enter,
  input  logic      pd_enter_active,
  input  logic      pd_exit,
  input  logic      slow_exit,
  output logic      rd_allowed,
  output pd_state_e state_q
);

  localparam int T_MAX = (T_FAST > T_SLOW) ? T_FAST : T_SLOW;
  localparam int CNT_W = $clog2(T_MAX + 1);

  pd_state_e        state_d;
  logic             kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  assign step_en = (state_q != PD_RUN) || pd_enter;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    case (state_q)
      PD_RUN: begin
        if (pd_enter) begin
          state_d = PD_DOWN;
          kind_d  = pd_enter_active;
        end
      end
      PD_DOWN: begin
        if (pd_exit) begin
          state_d = PD_WAIT;
          cnt_d   = (kind_q && slow_exit) ? CNT_W'(T_SLOW) : CNT_W'(T_FAST);
        end
      end
      PD_WAIT: begin
        if (cnt_q <= CNT_W'(1)) state_d = PD_RUN;
        else                    cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = PD_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_RUN;
      kind_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rd_allowed = (state_q == PD_RUN);

endmodule

// File: rtl/rdlat_valid_pipe.sv
`timescale 1ns/1ps
module rdlat_valid_pipe #(
  parameter int DEPTH     = 11,
  parameter int BURST_CYC = 2,
  parameter int LAT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic [LAT_W-1:0] lat,
  output logic             data_valid
);

  logic [DEPTH-1:0] pend_q, pend_d;
  logic             step_en;

  assign step_en = rd_go || (|pend_q);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic seed;
    assign seed = rd_go && (i >= int'(lat)) && (i < int'(lat) + BURST_CYC);
    if (i == DEPTH - 1) begin : g_top
      assign pend_d[i] = seed;
    end else begin : g_mid
      assign pend_d[i] = pend_q[i+1] | seed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (step_en) pend_q <= pend_d;
  end

  assign data_valid = pend_q[0];

endmodule

// File: rtl/ddr2_rd_lat_sched.sv
`timescale 1ns/1ps
module ddr2_rd_lat_sched
  import ddr2_rdlat_pkg::*;
#(
  parameter bit ENABLE_CL6 = 1'b0,
  parameter int BURST_LEN  = 4,
  parameter int AL_MAX     = 4,
  parameter int T_FAST     = 2,
  parameter int T_SLOW     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        rd_cmd,
  input  logic        pd_enter,
  input  logic        pd_enter_active,
  input  logic        pd_exit,
  output logic        data_valid,
  output logic        rd_allowed,
  output logic        cfg_error
);

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int CL_MAX    = ENABLE_CL6 ? 6 : 5;
  localparam int DEPTH     = AL_MAX + CL_MAX + BURST_CYC;
  localparam int LAT_W     = $clog2(DEPTH);

  logic              rst_core_n;
  logic [CL_W-1:0]   cl_q;
  logic [AL_W-1:0]   al_q;
  logic              slow_exit_q;
  pd_state_e         pd_state;
  logic              rd_go;
  logic [LAT_W-1:0]  lat;

  rdlat_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rdlat_cfg #(.ENABLE_CL6(ENABLE_CL6), .AL_MAX(AL_MAX), .RESET_CL(3)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .cl_q        (cl_q),
    .al_q        (al_q),
    .slow_exit_q (slow_exit_q),
    .cfg_error_q (cfg_error)
  );

  rdlat_pd_gate #(.T_FAST(T_FAST), .T_SLOW(T_SLOW)) u_pd (
    .clk             (clk),
    .rst_n           (rst_core_n),
    .pd_enter        (pd_enter),
    .pd_enter_active (pd_enter_active),
    .pd_exit         (pd_exit),
    .slow_exit       (slow_exit_q),
    .rd_allowed      (rd_allowed),
    .state_q         (pd_state)
  );

  assign rd_go = rd_cmd && rd_allowed;
  assign lat   = LAT_W'(al_q) + LAT_W'(cl_q);

  rdlat_valid_pipe #(.DEPTH(DEPTH), .BURST_CYC(BURST_CYC), .LAT_W(LAT_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rd_go      (rd_go),
    .lat        (lat),
    .data_valid (data_valid)
  );

endmodule

// File: rtl/rdlat_sched_chk.sv
`timescale 1ns/1ps
module rdlat_sched_chk
  import ddr2_rdlat_pkg::*;
#(
  parameter bit ENABLE_CL6 = 1'b0,
  parameter int AL_MAX     = 4
) (
  input logic        clk,
  input logic        rst_core_n,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [15:0] cfg_wdata,
  input logic        pd_enter,
  input logic        pd_exit,
  input logic        data_valid,
  input logic        rd_allowed,
  input logic        cfg_error,
  input logic [2:0]  cl_q,
  input logic [2:0]  al_q,
  input logic [1:0]  pd_state
);

  logic bad_cl_wr, good_cl_wr, bad_al_wr;

  assign bad_cl_wr  = cfg_we && !cfg_sel &&
                      ((cfg_wdata[6:4] < 3'd3) || (cfg_wdata[6:4] == 3'd7) ||
                       (cfg_wdata[6:4] == 3'd6 && !ENABLE_CL6));
  assign good_cl_wr = cfg_we && !cfg_sel && !bad_cl_wr;
  assign bad_al_wr  = cfg_we && cfg_sel && (int'(cfg_wdata[2:0]) > AL_MAX);

  assert_cl_legal_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cl_q == 3'd3) || (cl_q == 3'd4) || (cl_q == 3'd5) || (ENABLE_CL6 && cl_q == 3'd6));

  assert_reject_keeps_cl_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    bad_cl_wr |=> (cfg_error && $stable(cl_q)));

  assert_accept_clears_err_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    good_cl_wr |=> !cfg_error);

  assert_al_range_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    int'(al_q) <= AL_MAX);

  assert_reject_keeps_al_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    bad_al_wr |=> (cfg_error && $stable(al_q)));

  assert_burst_min_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(data_valid) |=> data_valid);

  assert_entry_blocks_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_allowed && pd_enter) |=> !rd_allowed);

  assert_exit_waits_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pd_state == PD_DOWN && pd_exit) |=> !rd_allowed);

endmodule

bind ddr2_rd_lat_sched rdlat_sched_chk #(.ENABLE_CL6(ENABLE_CL6), .AL_MAX(AL_MAX)) u_chk (.*);

// File: tb/ddr2_rd_lat_sched_bench.sv
`timescale 1ns/1ps
module ddr2_rd_lat_sched_bench;

  localparam int B  = 2;
  localparam int TF = 2;
  localparam int TS = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel, rd_cmd, pd_enter, pd_enter_active, pd_exit;
  logic [15:0] cfg_wdata;
  logic        data_valid, rd_allowed, cfg_error;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // behavioural reference state
  int  m_cl = 3, m_al = 0, m_st = 0, m_cnt = 0, cyc = 0;
  bit  m_slow = 0, m_err = 0, m_kind = 0;
  int  starts[$];

  always #4 clk = ~clk;

  ddr2_rd_lat_sched u_ddr2_rd_lat_sched (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_cmd(rd_cmd), .pd_enter(pd_enter), .pd_enter_active(pd_enter_active), .pd_exit(pd_exit),
    .data_valid(data_valid), .rd_allowed(rd_allowed), .cfg_error(cfg_error)
  );

  function automatic bit exp_dv();
    foreach (starts[k]) if (starts[k] <= cyc && cyc < starts[k] + B) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", cur_req, what, cyc, act, exp);
    end
  endtask

  task automatic compare();
    check1("data_valid", data_valid, exp_dv());
    check1("rd_allowed", rd_allowed, m_st == 0);
    check1("cfg_error",  cfg_error,  m_err);
  endtask

  task automatic model_edge();
    int f;
    cyc++;
    if (rd_cmd && m_st == 0) starts.push_back(cyc + m_al + m_cl);
    case (m_st)
      0: if (pd_enter) begin m_st = 1; m_kind = pd_enter_active; end
      1: if (pd_exit)  begin m_st = 2; m_cnt = (m_kind && m_slow) ? TS : TF; end
      default: if (m_cnt <= 1) m_st = 0; else m_cnt--;
    endcase
    if (cfg_we) begin
      if (!cfg_sel) begin
        f = int'(cfg_wdata[6:4]);
        if (f >= 3 && f <= 5) begin m_cl = f; m_slow = cfg_wdata[12]; m_err = 0; end
        else m_err = 1;
      end else begin
        f = int'(cfg_wdata[2:0]);
        if (f <= 4) begin m_al = f; m_err = 0; end
        else m_err = 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; rd_cmd = 0;
    pd_enter = 0; pd_enter_active = 0; pd_exit = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd();
    rd_cmd = 1; tick();
  endtask

  task automatic wr_mode(int cl, bit slow);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = '0;
    cfg_wdata[6:4] = 3'(cl); cfg_wdata[12] = slow; cfg_wdata[15] = 1'b1;
    tick();
  endtask

  task automatic wr_al(int al);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 16'hA5F8; cfg_wdata[2:0] = 3'(al);
    tick();
  endtask

  task automatic enter_pd(bit active);
    pd_enter = 1; pd_enter_active = active; tick();
  endtask

  task automatic exit_pd();
    pd_exit = 1; tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; rd_cmd = 0;
    pd_enter = 0; pd_enter_active = 0; pd_exit = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    idle(5);
    rd(); idle(6);                      // R1 default CL=3, AL=0

    cur_req = "R5";
    wr_mode(4, 0); rd(); idle(8);
    wr_al(2); wr_mode(5, 0); rd(); idle(10);
    wr_al(4); wr_mode(3, 0); rd(); idle(10);
    wr_al(0);

    cur_req = "R6";
    rd(); idle(1); rd(); idle(8);       // adjacent windows
    rd(); idle(3); rd(); idle(8);       // separated windows

    cur_req = "R7";
    for (int i = 0; i < 5; i++) rd();
    idle(8);
    wr_al(3); rd(); wr_al(0); rd(); rd(); idle(12);

    cur_req = "R2";
    wr_mode(6, 0); rd(); idle(8);       // 6 rejected by default build
    wr_mode(5, 0); rd(); idle(8);

    cur_req = "R3";
    wr_mode(2, 1); rd(); idle(8);
    wr_mode(7, 1); wr_mode(0, 1); wr_mode(1, 0);
    enter_pd(1); idle(2); exit_pd(); idle(6);   // exit bit must still be fast
    wr_mode(4, 0); rd(); idle(8);

    cur_req = "R4";
    wr_al(5); rd(); idle(8);
    wr_al(7); wr_al(3); rd(); idle(10);
    wr_al(0);

    cur_req = "R9";
    enter_pd(1); idle(2);
    cur_req = "R8";
    rd(); rd();
    cur_req = "R10";
    exit_pd();
    cur_req = "R8";
    rd(); rd(); rd(); idle(6);

    cur_req = "R10";
    wr_mode(3, 1);
    enter_pd(1); idle(1); exit_pd();
    for (int i = 0; i < 9; i++) rd();
    idle(6);

    cur_req = "R11";
    enter_pd(0); idle(2); exit_pd();
    for (int i = 0; i < 5; i++) rd();
    idle(6);

    cur_req = "R12";
    exit_pd(); idle(2);                 // exit while running
    enter_pd(1); enter_pd(0); idle(1);  // enter while down
    exit_pd(); enter_pd(1); idle(8);    // enter while waiting
    rd(); idle(6);
    wr_mode(3, 0);
    enter_pd(0); pd_exit = 1; pd_enter = 1; tick(); idle(4);

    finish_run();
  end

endmodule